// File: doc/BRIEF.md
# Sparse-Mapped Interrupt Controller

This block gathers sixty-four active-low interrupt inputs into one interrupt request line. Each input is given a fixed home in one of two 32-bit words, but the bit a source occupies does not follow its number: the placement follows a fixed, non-arithmetic pattern that software must mirror. For each word there is an enable (mask) register and a pending register, which software reads and writes over a simple single-cycle port with a word address and a write strobe.

Every input passes through a two-flop synchronizer. Most sources are sensed as active-low levels. Two ranges of sources can instead be switched to falling-edge sense by an edge-control register. In that mode a falling edge is captured and held until software clears it. The lowest-numbered source that is both pending and enabled is reported in a vector word. Source number zero acts as the "nothing pending" code.

Top module: `sparse_intc`

## Requirements
- R1: Word addresses are fixed: 0 selects the high enable word, 1 the low enable word, 2 the high pending word, 3 the low pending word, 4 edge control and 5 the vector. Reads return the selected word in the same cycle, and the other addresses read zero. Both enable words and edge control read zero after reset and read back what was last written.
- R2: The high word holds these sources. Source 0 sits at bit 0. Source k for k in 1..15 sits at bit 16-k. Source k for k in 32..47 sits at bit 63-k.
- R3: The low word holds these sources. Sources 16, 17 and 18 sit at bits 2, 1 and 0. Source k for k in 19..30 sits at bit 33-k. Source 31 sits at bit 0, which it shares with source 18. Source k for k in 48..63 sits at bit k-32. A bit that two sources share reads as their OR, and it enables or clears both sources.
- R4: A level-sensed source reads as pending exactly while its input is low, once the two synchronizer cycles have passed. Writing a one to its pending bit does not change it.
- R5: Sources 19..25 take their mode from edge-control bit 33-k, and sources 48..63 take theirs from bit 79-k. A one selects falling-edge sense and a zero selects low-level sense. In edge sense a falling input sets the pending bit and it stays set after the input returns high.
- R6: Writing a one to a pending bit clears a latched edge on every source mapped to that bit. Writing a zero leaves the bit unchanged.
- R7: The output irq is high exactly when some source numbered 1..63 is pending and its enable bit is one.
- R8: The vector word carries in bits 31:26 the lowest source number in 1..63 that is pending and enabled. It reads 0 when there is none, and bits 25:0 are always zero.
- R9: Edge-control bits do not change the sense of sources outside the two programmable ranges, which stay low-level sensed. A rising input never sets a pending bit.
- R10: Source 0 can show as pending at bit 0 of the high word, but it never raises irq and never appears in the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | 64 | Interrupt inputs, active low, bit k is source k |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word |
| irq | output | 1 | Interrupt request, high when an enabled source is pending |

## Verification
The assertions assume that wr_en and addr are always known values. They also assume that a clearing write and the capture of a falling edge on the same source do not fall in the same cycle. When that happens the capture wins. The stimulus changes src_n, the enable words or edge control only on falling clock edges, holds each change for four cycles so the synchronizer and edge capture settle, and only then compares all six words and irq with the bench model. Random source toggles, enable writes, clearing writes and edge-control writes run from a fixed seed. Directed cases cover the shared bit, source 0, a rising edge and the non-programmable sources.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int NSRC    = 64;
  localparam int DW      = 32;
  localparam int VEC_W   = 6;
  localparam int VEC_LSB = DW - VEC_W;

  typedef enum logic [2:0] {
    A_MASK_HI = 3'd0,
    A_MASK_LO = 3'd1,
    A_PEND_HI = 3'd2,
    A_PEND_LO = 3'd3,
    A_EDGE    = 3'd4,
    A_VEC     = 3'd5
  } sic_addr_e;

  // 1 when source s lives in the high word
  function automatic logic in_hi(input int s);
    return (s < 16) || (s >= 32 && s < 48);
  endfunction

  // bit position of source s inside its word
  function automatic logic [4:0] map_bit(input int s);
    if (s == 0)       return 5'd0;
    else if (s < 16)  return 5'(16 - s);
    else if (s < 19)  return 5'(18 - s);
    else if (s < 31)  return 5'(33 - s);
    else if (s == 31) return 5'd0;
    else if (s < 48)  return 5'(63 - s);
    else              return 5'(s - 32);
  endfunction

  function automatic logic edge_capable(input int s);
    return (s >= 19 && s <= 25) || (s >= 48 && s <= 63);
  endfunction

  function automatic logic [4:0] edge_bit(input int s);
    if (s >= 19 && s <= 25)      return 5'(33 - s);
    else if (s >= 48 && s <= 63) return 5'(79 - s);
    else                         return 5'd0;
  endfunction
endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sic_sense.sv
module sic_sense #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_n;
  logic [N-1:0] fall;
  logic [N-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= lvl_n;
  end

  assign fall = prev_n & ~lvl_n;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lat[i] <= 1'b0;
      else if (!edge_mode[i]) lat[i] <= 1'b0;
      else if (fall[i])       lat[i] <= 1'b1;
      else if (clr[i])        lat[i] <= 1'b0;
    end

    assign pend[i] = edge_mode[i] ? lat[i] : ~lvl_n[i];

    // R5: a captured edge holds until cleared
    a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[i] && lat[i] && !clr[i]) |=> lat[i]);
    // R9: an input sitting high cannot set the capture
    a_r9_high_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat[i] && lvl_n[i]) |=> !lat[i]);
  end
endmodule

// File: rtl/sic_prio.sv
module sic_prio #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [W-1:0] vec,
  output logic         any
);
  always_comb begin
    vec = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (req[i]) vec = W'(i);
    end
  end

  assign any = |req[N-1:1];

  // R8: a reported vector names a live request
  a_r8_vec_live: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '0) |-> req[vec]);
  // R7: a request always yields a nonzero vector
  a_r7_any_vec: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (vec != '0));
endmodule

// File: rtl/sparse_intc.sv
module sparse_intc
  import sic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  logic [DW-1:0]    mask_hi, mask_lo, edge_ctl;
  logic [NSRC-1:0]  lvl_n, em, clr, pend, en, req;
  logic [DW-1:0]    pend_hi, pend_lo;
  logic [VEC_W-1:0] vec;
  logic             any;

  sic_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_n), .q(lvl_n));

  // per-source view of the scattered registers
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      en[s]  = in_hi(s) ? mask_hi[map_bit(s)] : mask_lo[map_bit(s)];
      em[s]  = edge_capable(s) && edge_ctl[edge_bit(s)];
      clr[s] = wr_en && wdata[map_bit(s)] &&
               (addr == (in_hi(s) ? A_PEND_HI : A_PEND_LO));
    end
  end

  sic_sense #(.N(NSRC)) u_sense (
    .clk(clk), .rst_n(rst_n), .lvl_n(lvl_n), .edge_mode(em),
    .clr(clr), .pend(pend));

  always_comb begin
    pend_hi = '0;
    pend_lo = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (in_hi(s)) pend_hi[map_bit(s)] = pend_hi[map_bit(s)] | pend[s];
      else          pend_lo[map_bit(s)] = pend_lo[map_bit(s)] | pend[s];
    end
  end

  assign req = pend & en & {{(NSRC-1){1'b1}}, 1'b0};

  sic_prio #(.N(NSRC), .W(VEC_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(req), .vec(vec), .any(any));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi  <= '0;
      mask_lo  <= '0;
      edge_ctl <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MASK_HI: mask_hi  <= wdata;
        A_MASK_LO: mask_lo  <= wdata;
        A_EDGE:    edge_ctl <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_MASK_HI: rdata = mask_hi;
      A_MASK_LO: rdata = mask_lo;
      A_PEND_HI: rdata = pend_hi;
      A_PEND_LO: rdata = pend_lo;
      A_EDGE:    rdata = edge_ctl;
      A_VEC:     rdata = {vec, {VEC_LSB{1'b0}}};
      default:   rdata = '0;
    endcase
  end

  assign irq = any;

  // R1: an enable write lands in the next cycle
  a_r1_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK_LO) |=> (mask_lo == $past(wdata)));
  // R10: source 0 alone never raises the request line
  a_r10_src0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req[NSRC-1:1] == '0) |-> !irq);
  // R7: the request line follows the enabled pending set
  a_r7_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_hi & mask_hi) != '0 || (pend_lo & mask_lo) != '0));
endmodule

// File: tb/sparse_intc_test.sv
module sparse_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [63:0] lat_m = '0;
  logic [31:0] mhi_m = '0, mlo_m = '0, edg_m = '0;

  sparse_intc uut (.clk(clk), .rst_n(rst_n), .src_n(src_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  // placement restated by quarter and offset
  function automatic bit hi_of(int s);
    return (s / 16) % 2 == 0;
  endfunction
  function automatic int bit_of(int s);
    int k = s % 16;
    case (s / 16)
      0: return (k == 0) ? 0 : 16 - k;
      1: return (k < 3) ? 2 - k : ((k == 15) ? 0 : 17 - k);
      2: return 31 - k;
      default: return 16 + k;
    endcase
  endfunction
  function automatic bit edge_on(int s);
    if (s >= 19 && s <= 25) return edg_m[17 - (s % 16)];
    if (s >= 48)            return edg_m[31 - (s % 16)];
    return 1'b0;
  endfunction
  function automatic bit pend_of(int s);
    return edge_on(s) ? lat_m[s] : !src_n[s];
  endfunction
  function automatic bit en_of(int s);
    return hi_of(s) ? mhi_m[bit_of(s)] : mlo_m[bit_of(s)];
  endfunction
  function automatic logic [31:0] pword(bit hi);
    logic [31:0] r = '0;
    for (int s = 0; s < 64; s++)
      if (hi_of(s) == hi && pend_of(s)) r[bit_of(s)] = 1'b1;
    return r;
  endfunction
  function automatic int exp_vec();
    for (int s = 1; s < 64; s++) if (pend_of(s) && en_of(s)) return s;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string ctx);
    logic [31:0] d;
    int v;
    rd(3'd0, d); chk({"R1 mask_hi ", ctx}, d, mhi_m);
    rd(3'd1, d); chk({"R1 mask_lo ", ctx}, d, mlo_m);
    rd(3'd4, d); chk({"R1 edge ", ctx}, d, edg_m);
    rd(3'd2, d); chk({"R2 pend_hi ", ctx}, d, pword(1'b1));
    rd(3'd3, d); chk({"R3 pend_lo ", ctx}, d, pword(1'b0));
    v = exp_vec();
    rd(3'd5, d); chk({"R8 vector ", ctx}, d, {6'(v), 26'd0});
    chk({"R7 irq ", ctx}, {31'd0, irq}, {31'd0, v != 0});
  endtask

  task automatic set_src(int s, bit lvl);
    @(negedge clk);
    if (src_n[s] && !lvl && edge_on(s)) lat_m[s] = 1'b1;
    src_n[s] = lvl;
    settle();
  endtask

  task automatic w1c(bit hi, logic [31:0] d);
    wr(hi ? 3'd2 : 3'd3, d);
    for (int s = 0; s < 64; s++)
      if (hi_of(s) == hi && d[bit_of(s)] && edge_on(s)) lat_m[s] = 1'b0;
    settle();
  endtask

  task automatic set_edge(logic [31:0] d);
    logic [31:0] old = edg_m;
    wr(3'd4, d);
    edg_m = d;
    for (int s = 0; s < 64; s++) if (!edge_on(s)) lat_m[s] = 1'b0;
    if (old != d) settle(); else settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check_all("reset");
    rd(3'd6, d); chk("R1 unused addr", d, 32'd0);

    // R2 / R3 placement with everything enabled, one source at a time
    wr(3'd0, '1); mhi_m = '1;
    wr(3'd1, '1); mlo_m = '1;
    for (int s = 1; s < 64; s += 5) begin
      set_src(s, 1'b0);
      check_all("walk");
      set_src(s, 1'b1);
    end

    // R3 shared bit: sources 18 and 31 both at low bit 0
    set_src(31, 1'b0);
    rd(3'd3, d); chk("R3 shared bit", d, 32'h1);
    rd(3'd5, d); chk("R8 src31 vector", d, {6'd31, 26'd0});
    set_src(18, 1'b0);
    rd(3'd5, d); chk("R8 lower wins", d, {6'd18, 26'd0});
    set_src(18, 1'b1); set_src(31, 1'b1);

    // R10 source 0
    set_src(0, 1'b0);
    rd(3'd2, d); chk("R10 src0 pend", d, 32'h1);
    chk("R10 src0 irq", {31'd0, irq}, 32'd0);
    rd(3'd5, d); chk("R10 src0 vector", d, 32'd0);
    set_src(0, 1'b1);

    // R4 level ignores a clearing write
    set_src(40, 1'b0);
    w1c(1'b1, '1);
    rd(3'd2, d); chk("R4 level survives w1c", d, 32'h1 << 23);
    set_src(40, 1'b1);

    // R5 / R6 / R9 edge behaviour on source 50 and source 22
    set_edge(32'hFFFF_FFFF);
    set_src(50, 1'b0); set_src(50, 1'b1);
    rd(3'd3, d); chk("R5 edge held", d, 32'h1 << 18);
    w1c(1'b0, 32'h0);
    rd(3'd3, d); chk("R6 zero write keeps", d, 32'h1 << 18);
    w1c(1'b0, 32'h1 << 18);
    rd(3'd3, d); chk("R6 one write clears", d, 32'h0);
    set_src(22, 1'b0);
    w1c(1'b0, 32'h1 << 11);
    set_src(22, 1'b1);
    rd(3'd3, d); chk("R9 rising sets nothing", d, 32'h0);
    set_src(5, 1'b0);
    rd(3'd2, d); chk("R9 fixed source level", d, 32'h1 << 11);
    set_src(5, 1'b1);
    rd(3'd2, d); chk("R9 fixed source released", d, 32'h0);
    check_all("edge block");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 7);
      if (op <= 3) set_src($urandom_range(0, 63), 1'($urandom_range(0, 1)));
      else if (op == 4) begin
        d = $urandom(); wr(3'd0, d); mhi_m = d; settle();
      end else if (op == 5) begin
        d = $urandom(); wr(3'd1, d); mlo_m = d; settle();
      end else if (op == 6) w1c(1'($urandom_range(0, 1)), $urandom());
      else set_edge($urandom());
      check_all("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule